// File: doc/BRIEF.md
# Speculative Input-Channel Flow Controller

This block is the control state machine for one input channel of an on-chip packet router that sends flits ahead of routing. While the channel holds no flit, it takes an output port from an external predictor. It places a tentative (low-priority) request for that port with the switch arbiter. If the arbiter grants the request, the channel keeps that port as a held reservation.

When a head flit reaches the front of the input FIFO while the reservation is held, the flit is steered through the crossbar in the same cycle in which the external routing logic computes its real output port.

- **Prediction correct:** the flit is popped at once. The remaining flits of the packet follow on the same port, one per cycle.
- **Prediction wrong:** the flit stays in the FIFO. In the next cycle the controller pulses the kill line of the wrongly used output, so the copy sent there is discarded. In the same cycle it makes a firm request for the correct port, so the resend completes in the third cycle.
- **No reservation held:** the channel runs the ordinary sequence of route, allocate, traverse.

The controller produces one-hot request, crossbar-select and kill vectors. It consumes a one-hot grant vector, the FIFO front status and the routing result. The crossbar datapath lies outside the block.

Top module: `spec_chan_ctrl`

## Requirements
- R1: While reset is held and no flit or prediction is presented, `arb_req`, `xbar_sel`, `xbar_kill` and `flit_pop` are all zero.
- R2: With the channel idle, no flit waiting and `pred_vld` high, `arb_req` has exactly bit `pred_port` set (port index i maps to bit i of every one-hot vector), and `arb_tent` is 1.
- R3: With a reservation held and granted, a head flit that arrives is selected on the held port in its arrival cycle. If `route_port` equals the held port, `flit_pop` is high in that same cycle.
- R4: After a correctly predicted head, each following flit is selected on the same port and popped in any cycle where `flit_vld` is high. In a cycle where `flit_vld` is low, nothing is selected.
- R5: After the tail flit is popped, the channel returns to idle, and in the next cycle it makes a new tentative request for the current prediction.
- R6: On a wrong prediction, the flit is not popped in its arrival cycle. In the following cycle only, `xbar_kill` has the wrongly used port's bit set. Kill is never asserted at any other time.
- R7: In the kill cycle, the controller makes a firm request (`arb_tent` 0) for the routed port. If granted, the flit is selected on the routed port and popped in the third cycle counted from arrival.
- R8: A flit arriving while idle with no reservation is not selected in its arrival cycle. In the next cycle it is firmly requested on the routed port, and it is selected and popped in the cycle after the grant.
- R9: If the tentative request was not granted, a later flit takes the non-speculative path of R8 and no kill is produced.
- R10: While a reservation is held, `arb_req` stays on the held port even if the prediction changes. If the grant is withdrawn before a flit arrives, the reservation is dropped and the next flit is not sent speculatively.
- R11: In the allocation step, the controller keeps requesting the routed port and selects nothing until the grant arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_vld | input | 1 | FIFO front holds a flit |
| flit_tail | input | 1 | Front flit is the last of its packet |
| flit_pop | output | 1 | Remove the front flit from the FIFO |
| pred_vld | input | 1 | Predictor offers a port |
| pred_port | input | PORT_W | Predicted output port index |
| route_port | input | PORT_W | Routed output port of the front flit |
| arb_req | output | NUM_PORTS | One-hot output port request |
| arb_tent | output | 1 | Request is tentative (low priority) |
| arb_gnt | input | NUM_PORTS | One-hot grant from the arbiter |
| xbar_sel | output | NUM_PORTS | One-hot crossbar output select for the front flit |
| xbar_kill | output | NUM_PORTS | One-hot discard pulse to an output |

## Verification
The bench applies six patterns, each aimed at a different path through the controller:

1. **Correct prediction, multi-flit packet with a bubble:** shows that the one-cycle head transfer and the following flits share the held port and that an empty FIFO front does not advance.
2. **Single-flit wrong prediction:** separates the speculative select from the kill pulse and from the firm resend on the routed port.
3. **Withheld tentative grant:** shows that the channel falls back without a kill.
4. **No prediction at all:** checks the plain route, allocate, traverse timing.
5. **Withdrawn reservation:** shows that a stale reservation is not used for a later flit.
6. **Allocation without a grant:** checks that the controller waits in allocation.

A scoreboard compares the port of every popped flit with the port the bench expects, and counts the kill pulses.

// File: rtl/spec_chan_pkg.sv
package spec_chan_pkg;
    parameter int NUM_PORTS = 5;
    localparam int PORT_W = $clog2(NUM_PORTS);

    typedef logic [PORT_W-1:0]    port_t;
    typedef logic [NUM_PORTS-1:0] pvec_t;

    typedef enum logic [2:0] {
        CH_IDLE,   // no flit, optionally asking for a predicted port
        CH_RSV,    // tentative reservation held on the predicted port
        CH_KILL,   // wrong guess: discard pulse plus firm request
        CH_ALLOC,  // firm request on the routed port, waiting for grant
        CH_XFER    // port owned, flits stream until tail
    } ch_state_e;

    typedef struct packed {
        logic  en;
        port_t port;
    } port_cmd_t;

    localparam port_cmd_t CMD_NONE = '{en: 1'b0, port: '0};

    function automatic port_cmd_t mk_cmd(input port_t p);
        mk_cmd = '{en: 1'b1, port: p};
    endfunction
endpackage

// File: rtl/spec_port_dec.sv
module spec_port_dec
    import spec_chan_pkg::*;
(
    input  port_cmd_t cmd,
    output pvec_t     vec
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_bit
        assign vec[i] = cmd.en && (cmd.port == port_t'(i));
    end
endmodule

// File: rtl/spec_chan_fsm.sv
module spec_chan_fsm
    import spec_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flit_vld,
    input  logic      flit_tail,
    input  logic      pred_vld,
    input  port_t     pred_port,
    input  port_t     route_port,
    input  pvec_t     arb_gnt,
    output port_cmd_t req_cmd,
    output logic      req_tent,
    output port_cmd_t sel_cmd,
    output port_cmd_t kill_cmd,
    output logic      flit_pop
);
    ch_state_e st_q, st_d;
    port_t     held_q, held_d;   // speculatively reserved port
    port_t     rte_q, rte_d;     // confirmed routed port

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CH_IDLE;
            held_q <= '0;
            rte_q  <= '0;
        end else begin
            st_q   <= st_d;
            held_q <= held_d;
            rte_q  <= rte_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        held_d   = held_q;
        rte_d    = rte_q;
        req_cmd  = CMD_NONE;
        req_tent = 1'b0;
        sel_cmd  = CMD_NONE;
        kill_cmd = CMD_NONE;
        flit_pop = 1'b0;
        unique case (st_q)
            CH_IDLE: begin
                if (flit_vld) begin
                    // routing stage of the ordinary pipeline
                    rte_d = route_port;
                    st_d  = CH_ALLOC;
                end else if (pred_vld) begin
                    req_cmd  = mk_cmd(pred_port);
                    req_tent = 1'b1;
                    if (arb_gnt[pred_port]) begin
                        held_d = pred_port;
                        st_d   = CH_RSV;
                    end
                end
            end
            CH_RSV: begin
                req_cmd  = mk_cmd(held_q);
                req_tent = 1'b1;
                if (flit_vld && arb_gnt[held_q]) begin
                    sel_cmd = mk_cmd(held_q);
                    if (route_port == held_q) begin
                        flit_pop = 1'b1;
                        rte_d    = held_q;
                        st_d     = flit_tail ? CH_IDLE : CH_XFER;
                    end else begin
                        rte_d = route_port;
                        st_d  = CH_KILL;
                    end
                end else if (flit_vld) begin
                    rte_d = route_port;
                    st_d  = CH_ALLOC;
                end else if (!arb_gnt[held_q]) begin
                    st_d = CH_IDLE;
                end
            end
            CH_KILL: begin
                kill_cmd = mk_cmd(held_q);
                req_cmd  = mk_cmd(rte_q);
                st_d     = arb_gnt[rte_q] ? CH_XFER : CH_ALLOC;
            end
            CH_ALLOC: begin
                req_cmd = mk_cmd(rte_q);
                if (arb_gnt[rte_q]) st_d = CH_XFER;
            end
            CH_XFER: begin
                req_cmd = mk_cmd(rte_q);
                if (flit_vld) begin
                    sel_cmd  = mk_cmd(rte_q);
                    flit_pop = 1'b1;
                    if (flit_tail) st_d = CH_IDLE;
                end
            end
            default: st_d = CH_IDLE;
        endcase
    end
endmodule

// File: rtl/spec_chan_ctrl.sv
module spec_chan_ctrl
    import spec_chan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flit_vld,
    input  logic                 flit_tail,
    output logic                 flit_pop,
    input  logic                 pred_vld,
    input  logic [PORT_W-1:0]    pred_port,
    input  logic [PORT_W-1:0]    route_port,
    output logic [NUM_PORTS-1:0] arb_req,
    output logic                 arb_tent,
    input  logic [NUM_PORTS-1:0] arb_gnt,
    output logic [NUM_PORTS-1:0] xbar_sel,
    output logic [NUM_PORTS-1:0] xbar_kill
);
    port_cmd_t req_cmd, sel_cmd, kill_cmd;

    spec_chan_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .flit_vld   (flit_vld),
        .flit_tail  (flit_tail),
        .pred_vld   (pred_vld),
        .pred_port  (pred_port),
        .route_port (route_port),
        .arb_gnt    (arb_gnt),
        .req_cmd    (req_cmd),
        .req_tent   (arb_tent),
        .sel_cmd    (sel_cmd),
        .kill_cmd   (kill_cmd),
        .flit_pop   (flit_pop)
    );

    spec_port_dec u_req_dec  (.cmd(req_cmd),  .vec(arb_req));
    spec_port_dec u_sel_dec  (.cmd(sel_cmd),  .vec(xbar_sel));
    spec_port_dec u_kill_dec (.cmd(kill_cmd), .vec(xbar_kill));
endmodule

// File: rtl/spec_chan_chk.sv
module spec_chan_chk
    import spec_chan_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 flit_vld,
    input logic                 flit_tail,
    input logic                 flit_pop,
    input logic [NUM_PORTS-1:0] arb_req,
    input logic                 arb_tent,
    input logic [NUM_PORTS-1:0] arb_gnt,
    input logic [NUM_PORTS-1:0] xbar_sel,
    input logic [NUM_PORTS-1:0] xbar_kill
);
    assert_req_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(arb_req) && $onehot0(xbar_sel) && $onehot0(xbar_kill));

    assert_pop_has_sel_R3: assert property (@(posedge clk) disable iff (rst)
        flit_pop |-> (flit_vld && |xbar_sel));

    assert_hit_stays_R4: assert property (@(posedge clk) disable iff (rst)
        (arb_tent && flit_pop && !flit_tail) |=> (!flit_vld || xbar_sel == $past(xbar_sel)));

    assert_miss_kills_R6: assert property (@(posedge clk) disable iff (rst)
        (|xbar_sel && !flit_pop) |=> (xbar_kill == $past(xbar_sel)));

    assert_kill_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (|xbar_kill) |=> !(|xbar_kill));

    assert_spec_needs_gnt_R10: assert property (@(posedge clk) disable iff (rst)
        (arb_tent && |xbar_sel) |-> (|(xbar_sel & arb_gnt)));
endmodule

bind spec_chan_ctrl spec_chan_chk u_chk (.*);

// File: tb/sim_spec_chan_ctrl.sv
module sim_spec_chan_ctrl;
    import spec_chan_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 flit_vld = 1'b0, flit_tail = 1'b0, pred_vld = 1'b0;
    logic [PORT_W-1:0]    pred_port = '0, route_port = '0;
    logic [NUM_PORTS-1:0] gnt_mask = '1;
    logic [NUM_PORTS-1:0] arb_req, arb_gnt, xbar_sel, xbar_kill;
    logic                 arb_tent, flit_pop;

    int total = 0, bad = 0, kills = 0;
    bit finished = 0;
    int exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    assign arb_gnt = arb_req & gnt_mask;

    spec_chan_ctrl u0 (.*);

    function automatic logic [NUM_PORTS-1:0] oh(input int p);
        oh = NUM_PORTS'(1) << p;
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // drive one cycle of inputs, leave outputs settled for sampling
    task automatic cyc(input logic v, input logic t, input int r,
                       input logic pv, input int pp, input logic [NUM_PORTS-1:0] m);
        @(negedge clk);
        flit_vld   = v;
        flit_tail  = t;
        route_port = PORT_W'(r);
        pred_vld   = pv;
        pred_port  = PORT_W'(pp);
        gnt_mask   = m;
        #1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (|xbar_kill) kills++;
            if (flit_pop) begin
                if (exp_q.size() == 0) check("R3 unexpected pop", 32'(xbar_sel), 32'h0);
                else check("R3 popped port", 32'(xbar_sel), 32'(oh(exp_q.pop_front())));
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [NUM_PORTS-1:0] ALL = '1;
    localparam logic [NUM_PORTS-1:0] NONE = '0;

    initial begin
        cyc(0,0,0,0,0,ALL);
        cyc(0,0,0,0,0,ALL);
        check("R1 req", 32'(arb_req), 0);
        check("R1 sel", 32'(xbar_sel), 0);
        check("R1 kill", 32'(xbar_kill), 0);
        check("R1 pop", 32'(flit_pop), 0);
        rst = 1'b0;

        // correct prediction, three flits with a bubble
        cyc(0,0,0,1,1,ALL);
        check("R2 req", 32'(arb_req), 32'(oh(1)));
        check("R2 tent", 32'(arb_tent), 1);
        cyc(0,0,0,1,3,ALL);
        check("R10 held req", 32'(arb_req), 32'(oh(1)));
        exp_q.push_back(1);
        cyc(1,0,1,1,3,ALL);
        check("R3 hit sel", 32'(xbar_sel), 32'(oh(1)));
        check("R3 hit pop", 32'(flit_pop), 1);
        exp_q.push_back(1);
        cyc(1,0,1,0,0,ALL);
        check("R4 body sel", 32'(xbar_sel), 32'(oh(1)));
        cyc(0,0,1,0,0,ALL);
        check("R4 bubble sel", 32'(xbar_sel), 0);
        check("R4 bubble pop", 32'(flit_pop), 0);
        exp_q.push_back(1);
        cyc(1,1,1,0,0,ALL);
        check("R4 tail sel", 32'(xbar_sel), 32'(oh(1)));
        cyc(0,0,0,1,3,ALL);
        check("R5 new req", 32'(arb_req), 32'(oh(3)));
        check("R5 tent", 32'(arb_tent), 1);

        // wrong prediction, single flit
        cyc(1,1,0,0,0,ALL);
        check("R6 spec sel", 32'(xbar_sel), 32'(oh(3)));
        check("R6 no pop", 32'(flit_pop), 0);
        cyc(1,1,0,0,0,ALL);
        check("R6 kill", 32'(xbar_kill), 32'(oh(3)));
        check("R7 firm req", 32'(arb_req), 32'(oh(0)));
        check("R7 firm tent", 32'(arb_tent), 0);
        check("R7 no sel in kill", 32'(xbar_sel), 0);
        exp_q.push_back(0);
        cyc(1,1,0,0,0,ALL);
        check("R7 resend sel", 32'(xbar_sel), 32'(oh(0)));
        check("R7 resend pop", 32'(flit_pop), 1);
        check("R6 kill gone", 32'(xbar_kill), 0);

        // tentative request refused
        cyc(0,0,0,1,2,NONE);
        check("R9 tent req", 32'(arb_req), 32'(oh(2)));
        cyc(1,1,4,1,2,NONE);
        check("R9 no spec sel", 32'(xbar_sel), 0);
        check("R9 no kill", 32'(xbar_kill), 0);
        cyc(1,1,4,1,2,NONE);
        check("R11 wait req", 32'(arb_req), 32'(oh(4)));
        check("R11 wait sel", 32'(xbar_sel), 0);
        cyc(1,1,4,0,0,ALL);
        check("R11 grant sel", 32'(xbar_sel), 0);
        exp_q.push_back(4);
        cyc(1,1,4,0,0,ALL);
        check("R9 fallback sel", 32'(xbar_sel), 32'(oh(4)));
        check("R9 fallback kill", 32'(xbar_kill), 0);

        // no prediction: baseline three cycles
        cyc(1,1,2,0,0,ALL);
        check("R8 rc sel", 32'(xbar_sel), 0);
        check("R8 rc req", 32'(arb_req), 0);
        cyc(1,1,2,0,0,ALL);
        check("R8 alloc req", 32'(arb_req), 32'(oh(2)));
        check("R8 alloc tent", 32'(arb_tent), 0);
        exp_q.push_back(2);
        cyc(1,1,2,0,0,ALL);
        check("R8 st sel", 32'(xbar_sel), 32'(oh(2)));
        check("R8 st pop", 32'(flit_pop), 1);

        // reservation withdrawn
        cyc(0,0,0,1,1,ALL);
        cyc(0,0,0,1,1,NONE);
        check("R10 rsv req", 32'(arb_req), 32'(oh(1)));
        cyc(0,0,0,0,0,ALL);
        check("R10 dropped req", 32'(arb_req), 0);
        cyc(1,1,1,0,0,ALL);
        check("R10 no spec sel", 32'(xbar_sel), 0);
        cyc(1,1,1,0,0,ALL);
        exp_q.push_back(1);
        cyc(1,1,1,0,0,ALL);
        check("R10 late sel", 32'(xbar_sel), 32'(oh(1)));
        cyc(0,0,0,0,0,ALL);
        cyc(0,0,0,0,0,ALL);

        check("R3 scoreboard drained", 32'(exp_q.size()), 0);
        check("R6 kill count", 32'(kills), 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule